// File: doc/BRIEF.md
# H-Bridge Gate Command Sequencer

This block turns three digital control levels (enable, direction and PWM) into four gate commands for a full H-bridge built from two half-bridges. Each half-bridge has a high-side and a low-side transistor. A fixed mode table maps the direction and PWM levels to the set of transistors that should conduct. PWM high selects a braking state in which both high-sides conduct. When a transistor's command falls, the block turns it off at once. A newly commanded transistor is turned on only after a dead window of programmable length has passed, so the two transistors of one leg never conduct together.

Fault inputs take precedence over the mode table. Enable low releases every gate and floats the diagnostic. A thermal, overvoltage or undervoltage flag drives every gate to sink and pulls the diagnostic low. A per-transistor short-circuit vector holds only the flagged transistors in sink; the other transistors keep following the inputs, and the diagnostic reports the fault. All outputs are registered and change on the clock edge that first samples a new input level.

Top module: `hbridge_gate_ctrl`

## Requirements
- R1: When `enable` is 0, every gate output is 2'b00 (released) and `diagOut` is 2'b00 (floating), whatever the fault flags are.
- R2: With `enable` 1 and any of `thermFault`, `overVolt` or `underVolt` set, every gate is 2'b01 (sink) and `diagOut` is 2'b01 (low).
- R3: With no faults, `dirIn`=0 and `pwmIn`=0 settle to high-side 1 sink (01), low-side 1 source (10), high-side 2 source (10) and low-side 2 sink (01).
- R4: With no faults and `pwmIn`=1, the outputs settle, for either `dirIn`, to both high-sides source (10) and both low-sides sink (01).
- R5: With no faults, `dirIn`=1 and `pwmIn`=0 settle to high-side 1 source, low-side 1 sink, high-side 2 sink and low-side 2 source.
- R6: A transistor whose command falls shows sink on the first clock edge that samples the new `dirIn`/`pwmIn` level. A transistor whose command rises shows source D+1 edges after that edge, where D is `deadCycles`. A transistor commanded on both before and after the change stays at source.
- R7: Every change of `dirIn` or `pwmIn` restarts the dead window, including a change during a window that is already running.
- R8: The high-side and the low-side of one leg never both show source.
- R9: A set bit of `shortOff` (bit 3 high-side 1, bit 2 low-side 1, bit 1 high-side 2, bit 0 low-side 2) holds that gate in sink, leaves the others following the mode table, and drives `diagOut` to 2'b01.
- R10: With `enable` 1, no fault flags and `shortOff` all zero, `diagOut` is 2'b10 (high).
- R11: While `rst_n` is low, every gate is released and `diagOut` is floating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Activates the bridge; 0 releases all gates |
| dirIn | input | 1 | Motor direction level |
| pwmIn | input | 1 | PWM level; 1 selects braking |
| thermFault | input | 1 | Over-temperature shutdown flag |
| overVolt | input | 1 | Supply overvoltage shutdown flag |
| underVolt | input | 1 | Supply undervoltage shutdown flag |
| shortOff | input | 4 | Per-transistor short-circuit hold-off {HS1,LS1,HS2,LS2} |
| deadCycles | input | DT_W | Dead window length in clock cycles |
| gateHs1 | output | 2 | High-side 1 command (00 released, 01 sink, 10 source) |
| gateLs1 | output | 2 | Low-side 1 command |
| gateHs2 | output | 2 | High-side 2 command |
| gateLs2 | output | 2 | Low-side 2 command |
| diagOut | output | 2 | Diagnostic (00 floating, 01 low, 10 high) |

## Verification
The properties assume that every input is synchronous to `clk` and that `deadCycles` changes only while no window is running. They also assume the fault flags come from logic that is already registered, so a level seen on one edge is the level the design used. The stimulus drives every input on the falling edge and changes `deadCycles` only after the outputs have settled. The turn-on property compares each input with its value one edge earlier. It therefore relies on the direction and PWM levels being clean and free of glitches between edges, and the bench never drives them otherwise.

// File: rtl/hbg_pkg.sv
package hbg_pkg;
  typedef enum logic [1:0] {
    GATE_REL = 2'b00,
    GATE_SNK = 2'b01,
    GATE_SRC = 2'b10
  } gate_e;

  typedef enum logic [1:0] {
    DIAG_Z  = 2'b00,
    DIAG_LO = 2'b01,
    DIAG_HI = 2'b10
  } diag_e;

  localparam int NUM_SW = 4;
  localparam int IDX_HS1 = 3;
  localparam int IDX_LS1 = 2;
  localparam int IDX_HS2 = 1;
  localparam int IDX_LS2 = 0;

  // control-to-datapath strobes
  typedef struct packed {
    logic levelEdge;
    logic blockOn;
  } strobe_t;

  // conduction pattern {HS1,LS1,HS2,LS2} for a direction/PWM pair
  function automatic logic [NUM_SW-1:0] modeTarget(input logic dirLvl, input logic pwmLvl);
    if (pwmLvl)      return 4'b1010;
    else if (dirLvl) return 4'b1001;
    else             return 4'b0110;
  endfunction
endpackage

// File: rtl/hbg_ctrl.sv
module hbg_ctrl
  import hbg_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dirIn,
  input  logic            pwmIn,
  input  logic [DT_W-1:0] deadCycles,
  output strobe_t         strobes
);
  logic            dirPrev;
  logic            pwmPrev;
  logic [DT_W-1:0] deadCnt;
  logic            levelEdge;

  assign levelEdge = (dirIn ^ dirPrev) | (pwmIn ^ pwmPrev);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dirPrev <= 1'b0;
      pwmPrev <= 1'b0;
      deadCnt <= '0;
    end else begin
      dirPrev <= dirIn;
      pwmPrev <= pwmIn;
      if (levelEdge)
        deadCnt <= deadCycles;
      else if (deadCnt != '0)
        deadCnt <= deadCnt - 1'b1;
    end
  end

  always_comb begin
    strobes.levelEdge = levelEdge;
    strobes.blockOn   = levelEdge | (deadCnt != '0);
  end
endmodule

// File: rtl/hbg_datapath.sv
module hbg_datapath
  import hbg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           strobes,
  input  logic              enable,
  input  logic              dirIn,
  input  logic              pwmIn,
  input  logic              thermFault,
  input  logic              overVolt,
  input  logic              underVolt,
  input  logic [NUM_SW-1:0] shortOff,
  output gate_e             gateCmd [NUM_SW],
  output diag_e             diagLvl
);
  logic [NUM_SW-1:0] target;
  logic [NUM_SW-1:0] onState;
  logic [NUM_SW-1:0] onNext;
  logic              shutdown;

  // thermal, overvoltage and undervoltage share one forced-sink state
  assign shutdown = thermFault | overVolt | underVolt;
  assign target   = modeTarget(dirIn, pwmIn);

  for (genvar i = 0; i < NUM_SW; i++) begin : g_sw
    // off at once; on only outside the dead window
    assign onNext[i] = enable & ~shutdown & ~shortOff[i] & target[i]
                     & (onState[i] | ~strobes.blockOn);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        onState[i] <= 1'b0;
        gateCmd[i] <= GATE_REL;
      end else begin
        onState[i] <= onNext[i];
        if (!enable)       gateCmd[i] <= GATE_REL;
        else if (onNext[i]) gateCmd[i] <= GATE_SRC;
        else               gateCmd[i] <= GATE_SNK;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                     diagLvl <= DIAG_Z;
    else if (!enable)               diagLvl <= DIAG_Z;
    else if (shutdown || |shortOff) diagLvl <= DIAG_LO;
    else                            diagLvl <= DIAG_HI;
  end
endmodule

// File: rtl/hbridge_gate_ctrl.sv
module hbridge_gate_ctrl
  import hbg_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic            dirIn,
  input  logic            pwmIn,
  input  logic            thermFault,
  input  logic            overVolt,
  input  logic            underVolt,
  input  logic [3:0]      shortOff,
  input  logic [DT_W-1:0] deadCycles,
  output logic [1:0]      gateHs1,
  output logic [1:0]      gateLs1,
  output logic [1:0]      gateHs2,
  output logic [1:0]      gateLs2,
  output logic [1:0]      diagOut
);
  strobe_t strobes;
  gate_e   gateCmd [NUM_SW];
  diag_e   diagLvl;

  hbg_ctrl #(.DT_W(DT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .dirIn(dirIn), .pwmIn(pwmIn),
    .deadCycles(deadCycles), .strobes(strobes)
  );

  hbg_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .enable(enable),
    .dirIn(dirIn), .pwmIn(pwmIn), .thermFault(thermFault),
    .overVolt(overVolt), .underVolt(underVolt), .shortOff(shortOff),
    .gateCmd(gateCmd), .diagLvl(diagLvl)
  );

  assign gateHs1 = gateCmd[IDX_HS1];
  assign gateLs1 = gateCmd[IDX_LS1];
  assign gateHs2 = gateCmd[IDX_HS2];
  assign gateLs2 = gateCmd[IDX_LS2];
  assign diagOut = diagLvl;
endmodule

// File: rtl/hbg_checker.sv
module hbg_checker #(
  parameter int DT_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            enable,
  input logic            dirIn,
  input logic            pwmIn,
  input logic            thermFault,
  input logic            overVolt,
  input logic            underVolt,
  input logic [3:0]      shortOff,
  input logic [DT_W-1:0] deadCycles,
  input logic [1:0]      gateHs1,
  input logic [1:0]      gateLs1,
  input logic [1:0]      gateHs2,
  input logic [1:0]      gateLs2,
  input logic [1:0]      diagOut
);
  assert_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (gateHs1 == 2'b00 && gateLs1 == 2'b00 && gateHs2 == 2'b00
                 && gateLs2 == 2'b00 && diagOut == 2'b00));

  assert_shutdown_sink_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && (thermFault || overVolt || underVolt)) |=>
      (gateHs1 == 2'b01 && gateLs1 == 2'b01 && gateHs2 == 2'b01
       && gateLs2 == 2'b01 && diagOut == 2'b01));

  assert_no_early_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && (dirIn != $past(dirIn) || pwmIn != $past(pwmIn))) |=>
      !((gateHs1 == 2'b10 && $past(gateHs1) != 2'b10) ||
        (gateLs1 == 2'b10 && $past(gateLs1) != 2'b10) ||
        (gateHs2 == 2'b10 && $past(gateHs2) != 2'b10) ||
        (gateLs2 == 2'b10 && $past(gateLs2) != 2'b10)));

  assert_leg1_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(gateHs1 == 2'b10 && gateLs1 == 2'b10));

  assert_leg2_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(gateHs2 == 2'b10 && gateLs2 == 2'b10));

  assert_short_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && shortOff[3]) |=> (gateHs1 == 2'b01 && diagOut == 2'b01));

  assert_diag_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !thermFault && !overVolt && !underVolt && shortOff == 4'b0000)
      |=> diagOut == 2'b10);
endmodule

bind hbridge_gate_ctrl hbg_checker #(.DT_W(DT_W)) u_chk (.*);

// File: tb/hbridge_gate_ctrl_bench.sv
module hbridge_gate_ctrl_bench;
  localparam int DT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, dirIn = 1'b0, pwmIn = 1'b0;
  logic thermFault = 1'b0, overVolt = 1'b0, underVolt = 1'b0;
  logic [3:0] shortOff = 4'b0000;
  logic [DT_W-1:0] deadCycles = 8'd3;
  logic [1:0] gateHs1, gateLs1, gateHs2, gateLs2, diagOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hbridge_gate_ctrl #(.DT_W(DT_W)) u_hbridge_gate_ctrl (.*);

  // {en,dir,pwm,therm,ov,uv} {shortOff} {HS1,LS1,HS2,LS2} {diag}
  localparam logic [19:0] VEC [0:13] = '{
    {6'b100000, 4'b0000, 8'b01101001, 2'b10},
    {6'b110000, 4'b0000, 8'b10010110, 2'b10},
    {6'b101000, 4'b0000, 8'b10011001, 2'b10},
    {6'b111000, 4'b0000, 8'b10011001, 2'b10},
    {6'b000000, 4'b0000, 8'b00000000, 2'b00},
    {6'b100100, 4'b0000, 8'b01010101, 2'b01},
    {6'b100010, 4'b0000, 8'b01010101, 2'b01},
    {6'b100001, 4'b0000, 8'b01010101, 2'b01},
    {6'b100111, 4'b0000, 8'b01010101, 2'b01},
    {6'b100000, 4'b0100, 8'b01011001, 2'b01},
    {6'b110000, 4'b0001, 8'b10010101, 2'b01},
    {6'b101000, 4'b1000, 8'b01011001, 2'b01},
    {6'b000100, 4'b0000, 8'b00000000, 2'b00},
    {6'b100000, 4'b0010, 8'b01100101, 2'b01}
  };

  task automatic check(input string req, input string what, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  function automatic logic [9:0] outs();
    return {gateHs1, gateLs1, gateHs2, gateLs2, diagOut};
  endfunction

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog run did not finish");
      summary();
    end
  end

  initial begin
    string tag;
    // R11: reset state
    repeat (3) @(posedge clk);
    #1 check("R11", "reset", outs(), 10'b0000000000);
    @(negedge clk) rst_n = 1'b1;

    // table walk with a 3-cycle dead window
    for (int v = 0; v < 14; v++) begin
      @(negedge clk);
      {enable, dirIn, pwmIn, thermFault, overVolt, underVolt} = VEC[v][19:14];
      shortOff = VEC[v][13:10];
      repeat (8) @(posedge clk);
      #1;
      if (!VEC[v][19])                 tag = "R1";
      else if (|VEC[v][16:14])         tag = "R2";
      else if (|VEC[v][13:10])         tag = "R9";
      else if (VEC[v][17])             tag = "R4";
      else if (VEC[v][18])             tag = "R5";
      else                             tag = "R3";
      check(tag, $sformatf("vector %0d", v), outs(), VEC[v][9:0]);
      if (tag == "R3" || tag == "R4" || tag == "R5")
        check("R10", "diag high", {8'b0, diagOut}, {8'b0, 2'b10});
    end

    // R6: turn-off immediate, turn-on after D+1 edges, D=4
    @(negedge clk);
    {enable, dirIn, pwmIn, thermFault, overVolt, underVolt} = 6'b100000;
    shortOff = 4'b0000;
    deadCycles = 8'd4;
    repeat (8) @(posedge clk);
    @(negedge clk) pwmIn = 1'b1;
    @(posedge clk); #1;
    check("R6", "ls1 off at once", {8'b0, gateLs1}, {8'b0, 2'b01});
    check("R6", "hs2 stays on", {8'b0, gateHs2}, {8'b0, 2'b10});
    for (int k = 1; k <= 4; k++) begin
      @(posedge clk); #1;
      check("R6", $sformatf("hs1 held edge %0d", k), {8'b0, gateHs1}, {8'b0, 2'b01});
    end
    @(posedge clk); #1;
    check("R6", "hs1 on after window", {8'b0, gateHs1}, {8'b0, 2'b10});

    // R7: restart during a running window
    @(negedge clk) pwmIn = 1'b0;
    repeat (8) @(posedge clk);
    @(negedge clk) pwmIn = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk) dirIn = 1'b1;
    for (int k = 2; k <= 6; k++) begin
      @(posedge clk); #1;
      check("R7", $sformatf("hs1 held edge %0d", k), {8'b0, gateHs1}, {8'b0, 2'b01});
    end
    @(posedge clk); #1;
    check("R7", "hs1 on after restarted window", {8'b0, gateHs1}, {8'b0, 2'b10});

    // R6 with zero dead window: from brake to dir=1
    @(negedge clk) deadCycles = 8'd0;
    repeat (3) @(posedge clk);
    @(negedge clk) pwmIn = 1'b0;
    @(posedge clk); #1;
    check("R6", "hs2 off, ls2 waits", {6'b0, gateHs2, gateLs2}, {6'b0, 2'b01, 2'b01});
    check("R6", "hs1 kept on", {8'b0, gateHs1}, {8'b0, 2'b10});
    @(posedge clk); #1;
    check("R6", "ls2 on after one edge", {8'b0, gateLs2}, {8'b0, 2'b10});

    // R1: enable low dominates a shutdown fault
    @(negedge clk) begin enable = 1'b0; overVolt = 1'b1; end
    @(posedge clk); #1;
    check("R1", "disable with fault", outs(), 10'b0000000000);

    done = 1'b1;
    summary();
  end
endmodule